// File: doc/BRIEF.md
# Multi-Channel Input Word Collector

This block collects input words from several peripheral channels onto one accumulator input path. Each channel presents an 18-bit data word and one strobe. The strobe qualifies every bit of that channel's word. On a clock edge, the words of all strobed channels are merged bit by bit with OR. The merged word can only set accumulator bits. Bits that are already set stay set, and an unstrobed channel leaves the accumulator unchanged.

A separate clear input empties the accumulator before a collect operation. The base build has seven channels (indices 0 to 6). An expansion parameter adds seven more channels (indices 7 to 13), and these join the same per-bit merge. Without the expansion, strobes on indices 7 to 13 are ignored. A single channel may carry several independent fields at fixed bit positions, such as status flags in the low bits and a small counter in the high bits. Each field lands at its own bit positions in the accumulator.

Top module: `wordCollector`

## Requirements
- R1: While `rstN` is low, `accWord` is 0.
- R2: A channel whose `chanStrobe` bit is 1 at a rising clock edge ORs its 18-bit word into `accWord`. The result is visible after that edge. Channel c's word occupies `chanData[c*18 +: 18]`.
- R3: A channel whose strobe is 0 has no effect on `accWord`, whatever its data.
- R4: When several channels are strobed at the same edge, `accWord` receives the bitwise OR of all their words.
- R5: Without a clear, no accumulator bit ever goes from 1 to 0. Collection only sets bits.
- R6: `accClear` high at an edge zeroes the accumulator. If strobes are active at that same edge, the result is exactly the merged word of the strobed channels.
- R7: With `HAS_EXP`=1, channels 7 to 13 take part in the merge exactly like channels 0 to 6.
- R8: With `HAS_EXP`=0, strobes on channels 7 to 13 are ignored and leave `accWord` unchanged.
- R9: Bit i of a channel word sets accumulator bit i. A word with a 9-bit field in bits 8:0 and a 6-bit field in bits 17:12 places both fields unchanged in `accWord` bits 8:0 and 17:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accClear | input | 1 | Zeroes the accumulator at the next edge |
| chanStrobe | input | 14 | One strobe per channel, bit c for channel c |
| chanData | input | 252 | Channel words, channel c at bits c*18 +: 18 |
| accWord | output | 18 | Accumulator contents |

## Verification
The accumulator is the only state, and it feeds `accWord` directly. A wrong gate, a bad mask or a faulty clear therefore shows at the port one edge after the stimulus. Because collection only sets bits, a bit that is wrongly set stays visible until the next clear. A bit that is wrongly dropped breaks the set-only property at once. Random strobe patterns are checked every cycle against a bench model, using a build with the expansion and a build without it. This exposes any leak from unstrobed or masked channels within one cycle.

// File: rtl/collectPkg.sv
package collectPkg;
  localparam int WORD_W   = 18;
  localparam int BASE_CH  = 7;
  localparam int EXP_CH   = 7;
  localparam int TOTAL_CH = BASE_CH + EXP_CH;

  typedef struct packed {
    logic                clearAcc;
    logic [TOTAL_CH-1:0] gateMask;
  } collectCtrl_t;
endpackage

// File: rtl/collectControl.sv
module collectControl
  import collectPkg::*;
#(
  parameter bit HAS_EXP = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accClear,
  input  logic [TOTAL_CH-1:0] chanStrobe,
  output collectCtrl_t        ctrlBus
);
  logic [TOTAL_CH-1:0] effMask;

  generate
    if (HAS_EXP) begin : g_withExp
      assign effMask = chanStrobe;
    end else begin : g_baseOnly
      logic [EXP_CH-1:0] unusedExp;
      assign unusedExp = chanStrobe[TOTAL_CH-1:BASE_CH];
      assign effMask = {{EXP_CH{1'b0}}, chanStrobe[BASE_CH-1:0]};
    end
  endgenerate

  assign ctrlBus.clearAcc = accClear;
  assign ctrlBus.gateMask = effMask;

  // R2: only channels that carry a strobe may be gated.
  assert_mask_subset_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.gateMask & ~chanStrobe) == '0);
endmodule

// File: rtl/collectDatapath.sv
module collectDatapath
  import collectPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  collectCtrl_t               ctrlBus,
  input  logic [TOTAL_CH*WORD_W-1:0] chanData,
  output logic [WORD_W-1:0]          accWord
);
  logic [WORD_W-1:0] gated [TOTAL_CH];
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] accQ;

  for (genvar c = 0; c < TOTAL_CH; c++) begin : g_gate
    assign gated[c] = chanData[c*WORD_W +: WORD_W] & {WORD_W{ctrlBus.gateMask[c]}};
  end

  always_comb begin
    merged = '0;
    for (int c = 0; c < TOTAL_CH; c++) merged = merged | gated[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accQ <= '0;
    else if (ctrlBus.clearAcc) accQ <= merged;
    else accQ <= accQ | merged;
  end

  assign accWord = accQ;

  // R5: without a clear, set bits stay set.
  assert_set_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBus.clearAcc |=> ((accQ & $past(accQ)) == $past(accQ)));
  // R6: after a clear, only bits from the merged word may remain.
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.clearAcc |=> ((accQ & ~$past(merged)) == '0));
  // R3: a newly set bit must come from a gated channel.
  assert_no_stray_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((accQ & ~$past(accQ) & ~$past(merged)) == '0));
  // R4: every merged bit appears in the accumulator.
  assert_merge_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((accQ & $past(merged)) == $past(merged)));
endmodule

// File: rtl/wordCollector.sv
module wordCollector
  import collectPkg::*;
#(
  parameter bit HAS_EXP = 1'b1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       accClear,
  input  logic [TOTAL_CH-1:0]        chanStrobe,
  input  logic [TOTAL_CH*WORD_W-1:0] chanData,
  output logic [WORD_W-1:0]          accWord
);
  collectCtrl_t ctrlBus;

  collectControl #(.HAS_EXP(HAS_EXP)) u_ctrl (
    .clk(clk), .rstN(rstN), .accClear(accClear),
    .chanStrobe(chanStrobe), .ctrlBus(ctrlBus)
  );

  collectDatapath u_dp (
    .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus),
    .chanData(chanData), .accWord(accWord)
  );
endmodule

// File: tb/wordCollector_bench.sv
module wordCollector_bench;
  import collectPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accClear = 1'b0;
  logic [TOTAL_CH-1:0] chanStrobe = '0;
  logic [TOTAL_CH*WORD_W-1:0] chanData = '0;
  logic [WORD_W-1:0] accFull, accBase;
  logic [WORD_W-1:0] expFull, expBase;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wordCollector #(.HAS_EXP(1'b1)) u_wordCollector (
    .clk(clk), .rstN(rstN), .accClear(accClear), .chanStrobe(chanStrobe),
    .chanData(chanData), .accWord(accFull));
  wordCollector #(.HAS_EXP(1'b0)) u_wordCollector_base (
    .clk(clk), .rstN(rstN), .accClear(accClear), .chanStrobe(chanStrobe),
    .chanData(chanData), .accWord(accBase));

  function automatic logic [WORD_W-1:0] mergeOf(logic [TOTAL_CH-1:0] stb,
      logic [TOTAL_CH*WORD_W-1:0] d, int nCh);
    logic [WORD_W-1:0] m = '0;
    for (int c = 0; c < nCh; c++) if (stb[c]) m |= d[c*WORD_W +: WORD_W];
    return m;
  endfunction

  task automatic check(string tag, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic setCh(int c, logic [WORD_W-1:0] w);
    chanData[c*WORD_W +: WORD_W] = w;
  endtask

  // Drives one cycle at negedge, updates models, checks at following negedge.
  task automatic cycle(string tag, logic clr, logic [TOTAL_CH-1:0] stb);
    accClear = clr;
    chanStrobe = stb;
    expFull = (clr ? '0 : expFull) | mergeOf(stb, chanData, TOTAL_CH);
    expBase = (clr ? '0 : expBase) | mergeOf(stb, chanData, BASE_CH);
    @(negedge clk);
    check({tag, " full"}, accFull, expFull);
    check({tag, " base"}, accBase, expBase);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    expFull = '0; expBase = '0;
    repeat (3) @(negedge clk);
    check("R1 reset full", accFull, '0);
    check("R1 reset base", accBase, '0);
    rstN = 1'b1;
    @(negedge clk);

    setCh(0, 18'h15555);
    cycle("R2 single strobe", 1'b0, 14'h0001);
    setCh(1, 18'h3FFFF);
    cycle("R3 unstrobed data", 1'b0, 14'h0000);
    setCh(2, 18'h00A00);
    cycle("R5 set only", 1'b0, 14'h0004);
    cycle("R6 clear alone", 1'b1, 14'h0000);
    setCh(3, 18'h2468A);
    cycle("R6 clear with strobe", 1'b1, 14'h0008);
    setCh(4, 18'h000FF); setCh(5, 18'h3F000);
    cycle("R4 clear prep", 1'b1, 14'h0000);
    cycle("R4 merge two", 1'b0, 14'h0030);
    cycle("R7 R8 clear", 1'b1, 14'h0000);
    setCh(10, 18'h1C3C3);
    cycle("R7 R8 expansion strobe", 1'b0, 14'h0400);
    check("R8 base ignores expansion", accBase, '0);
    setCh(13, 18'h20001);
    cycle("R7 expansion merge", 1'b0, 14'h2001);
    setCh(6, (18'(45) << 12) | 18'h1A5);
    cycle("R9 field prep", 1'b1, 14'h0040);
    check("R9 status field", {9'h0, accFull[8:0]}, 18'h1A5);
    check("R9 counter field", {12'h0, accFull[17:12]}, 18'd45);

    for (int i = 0; i < 400; i++) begin
      for (int c = 0; c < TOTAL_CH; c++) setCh(c, WORD_W'($urandom));
      cycle("R2 R3 R4 R5 R6 R7 R8 random", ($urandom % 12) == 0,
            TOTAL_CH'($urandom & $urandom & $urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule